// File: doc/BRIEF.md
# Dual-Rate Token Bucket Meter

This block limits the egress rate of a set of channels. Each channel owns a meter with two token buckets, a commit bucket and a peak bucket. On every tick each bucket gains a programmable number of tokens, given as an integer with a 6-bit fraction, and it stops filling at a ceiling of 2^shift. A packet presented on the packet port passes (conform) only when both buckets of its meter hold at least its cost. A passing packet draws its cost from both buckets. A refused packet (exceed) leaves the buckets unchanged. The egress logic uses the decision to gate the packet.

Every setting is reached through one indirect command port. A command word names the operation (read or write), the parameter type, the meter and the bucket. A write takes its value from the low data word, which is presented in the same cycle as the command. A read returns its result in the low and high data words, and a done flag marks that the command has completed. The tick comes from a global fast tick period. A meter can select a slower tick instead: one slow tick for every `tick_ratio` fast ticks.

Top module: `dual_bucket_meter`

## Requirements
- R1: A command is taken in the cycle `cmd_valid` is high. In the following cycle `cmd_done` reads 1 and holds there, and for a read `rdata_lo`/`rdata_hi` carry the result. `cmd_done` is 0 out of reset. Command word fields: bit 31 selects write (1) or read (0), bits 29:28 give the parameter type, bits 27:26 the meter group, bits 23:17 the meter index, and bit 16 the bucket.
- R2: The meter number is group*128 + index. A command whose meter number is not below NUM_METERS changes nothing, and a read to it returns 0 in both data words.
- R3: Parameter type 0 is a per-meter control word. Bit 0 selects the slow tick, bit 1 selects packet mode, and bit 2 enables the meter. All three bits are 0 out of reset.
- R4: Parameter type 1 is the token rate. Bits 23:6 hold the integer tokens per tick and bits 5:0 hold a fraction in 1/64 units. Each tick adds the full rate to the bucket, and the fractional remainder is carried into the next tick.
- R5: Parameter type 2 is the bucket size shift, reset to 12. A written value below 12 is stored as 12, and a written value above 17 is stored as 17.
- R6: A bucket never holds more than 2^shift tokens. Filling stops at that ceiling and the fraction is cleared there.
- R7: When `tick_fast` is nonzero, a fast tick occurs every `tick_fast` clock cycles; when it is 0, no fast tick occurs. A slow tick occurs on every `tick_ratio`-th fast tick, and never when the ratio is 0. A meter with the slow-tick bit set fills only on slow ticks.
- R8: For an enabled meter, `dec_valid` rises one cycle after `pkt_valid`. `dec_conform` is 1 when both buckets hold at least the packet cost, which is `pkt_len` in byte mode and 1 in packet mode. On conform the cost is drawn from both buckets; on exceed neither bucket changes. A packet in the next cycle sees the updated levels.
- R9: A packet sent to a disabled meter always conforms and does not change its buckets.
- R10: Parameter type 3 is the bucket level. A read returns the integer level in `rdata_lo` and the fraction in `rdata_hi`. A write sets the integer level, clamped to 2^shift, and clears the fraction.
- R11: The bucket bit of the command selects the commit bucket (0) or the peak bucket (1). Each bucket keeps its own rate, shift and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_fast | input | 16 | Fast tick period in clock cycles, 0 stops ticking |
| tick_ratio | input | 14 | Fast ticks per slow tick, 0 stops slow ticks |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 32 | Command word |
| wdata_lo | input | 32 | Write data |
| cmd_done | output | 1 | Command completed |
| rdata_lo | output | 32 | Read data, low word |
| rdata_hi | output | 32 | Read data, high word (level fraction) |
| pkt_valid | input | 1 | Packet presented for metering |
| pkt_meter | input | MID_W | Meter of the packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| dec_valid | output | 1 | Decision valid |
| dec_conform | output | 1 | 1 = conform, 0 = exceed |

## Verification
The bench builds the block with NUM_METERS = 3. Because 3 is not a power of two, meter number 3 has a valid index encoding but no meter behind it, so the out-of-range path can be reached. Meter 128, reached through the group field, exercises that path as well. The tick inputs are held at 0 and then raised to a period of 1 for an exact number of cycles, which gives an exact tick count. From that count the bench predicts levels to the 1/64 fraction, the ceiling at 2^12, and the 1-in-4 slow-tick division. Decisions are checked at the equality boundary, in packet mode, back to back on one meter, and on a disabled meter.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
   localparam int FRAC_W    = 6;
   localparam int INT_W     = 18;
   localparam int SHIFT_MIN = 12;
   localparam int SHIFT_MAX = 17;
   localparam int MNUM_W    = 9;

   typedef enum logic [1:0] {
      PT_CTRL  = 2'd0,
      PT_RATE  = 2'd1,
      PT_SHIFT = 2'd2,
      PT_LEVEL = 2'd3
   } param_t;
endpackage

// File: rtl/dbm_tick_gen.sv
module dbm_tick_gen (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] fast_period,
   input  logic [13:0] slow_ratio,
   output logic        fast_tick,
   output logic        slow_tick
);
   logic [15:0] fast_cnt;
   logic [13:0] slow_cnt;

   assign fast_tick = (fast_period != 16'd0) && (fast_cnt >= fast_period - 16'd1);
   assign slow_tick = fast_tick && (slow_ratio != 14'd0) && (slow_cnt >= slow_ratio - 14'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_cnt <= '0;
         slow_cnt <= '0;
      end else begin
         if (fast_period == 16'd0 || fast_tick) fast_cnt <= '0;
         else                                   fast_cnt <= fast_cnt + 16'd1;
         if (slow_ratio == 14'd0 || slow_tick) slow_cnt <= '0;
         else if (fast_tick)                   slow_cnt <= slow_cnt + 14'd1;
      end
   end

   a_r7_fast_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_tick && fast_period > 16'd1) |=> (!fast_tick || fast_period <= 16'd1));
   a_r7_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_tick && slow_ratio > 14'd1) |=> (!slow_tick || slow_ratio <= 14'd1));
endmodule

// File: rtl/dbm_bucket.sv
module dbm_bucket #(
   parameter int INT_W     = 18,
   parameter int FRAC_W    = 6,
   parameter int SHIFT_MIN = 12,
   parameter int SHIFT_MAX = 17
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    wr_rate,
   input  logic                    wr_shift,
   input  logic                    wr_level,
   input  logic [31:0]             wdata,
   input  logic                    take,
   input  logic [INT_W-1:0]        cost,
   output logic [INT_W+FRAC_W-1:0] rate_o,
   output logic [4:0]              shift_o,
   output logic [INT_W-1:0]        lvl_int_o,
   output logic [FRAC_W-1:0]       lvl_frac_o
);
   localparam int FX_W = INT_W + FRAC_W;

   if (SHIFT_MAX >= INT_W || SHIFT_MIN > SHIFT_MAX || SHIFT_MAX > 31) begin : g_bad_cfg
      $fatal(1, "dbm_bucket: shift range does not fit the level width");
   end

   logic [FX_W-1:0] rate_q, lvl_q, cap_fx, new_cap, drained, next_lvl, wr_lvl;
   logic [FX_W:0]   sum;
   logic [4:0]      shift_q, new_shift;

   function automatic logic [4:0] clamp_shift(input logic [31:0] v);
      if (v < 32'(SHIFT_MIN))      return 5'(SHIFT_MIN);
      else if (v > 32'(SHIFT_MAX)) return 5'(SHIFT_MAX);
      else                         return v[4:0];
   endfunction

   always_comb begin
      cap_fx    = FX_W'(1) << (int'(shift_q) + FRAC_W);
      new_shift = clamp_shift(wdata);
      new_cap   = FX_W'(1) << (int'(new_shift) + FRAC_W);
      drained   = take ? lvl_q - {cost, {FRAC_W{1'b0}}} : lvl_q;
      sum       = {1'b0, drained} + (tick ? {1'b0, rate_q} : '0);
      next_lvl  = (sum >= {1'b0, cap_fx}) ? cap_fx : sum[FX_W-1:0];
      wr_lvl    = {wdata[INT_W-1:0], {FRAC_W{1'b0}}};
      if (wr_lvl > cap_fx) wr_lvl = cap_fx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q  <= '0;
         shift_q <= 5'(SHIFT_MIN);
         lvl_q   <= '0;
      end else begin
         if (wr_rate) rate_q <= wdata[FX_W-1:0];
         if (wr_shift) begin
            shift_q <= new_shift;
            lvl_q   <= (lvl_q > new_cap) ? new_cap : lvl_q;
         end else if (wr_level) begin
            lvl_q <= wr_lvl;
         end else begin
            lvl_q <= next_lvl;
         end
      end
   end

   assign rate_o     = rate_q;
   assign shift_o    = shift_q;
   assign lvl_int_o  = lvl_q[FX_W-1:FRAC_W];
   assign lvl_frac_o = lvl_q[FRAC_W-1:0];

   a_r6_level_capped: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= cap_fx);
   a_r5_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_q >= 5'(SHIFT_MIN)) && (shift_q <= 5'(SHIFT_MAX)));
   a_r8_take_covered: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (lvl_int_o >= cost));
endmodule

// File: rtl/dual_bucket_meter.sv
module dual_bucket_meter
   import dbm_pkg::*;
#(
   parameter int NUM_METERS = 4,
   parameter int LEN_W      = 16,
   parameter int MID_W      = (NUM_METERS > 1) ? $clog2(NUM_METERS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      tick_fast,
   input  logic [13:0]      tick_ratio,
   input  logic             cmd_valid,
   input  logic [31:0]      cmd_word,
   input  logic [31:0]      wdata_lo,
   output logic             cmd_done,
   output logic [31:0]      rdata_lo,
   output logic [31:0]      rdata_hi,
   input  logic             pkt_valid,
   input  logic [MID_W-1:0] pkt_meter,
   input  logic [LEN_W-1:0] pkt_len,
   output logic             dec_valid,
   output logic             dec_conform
);
   localparam int FX_W = INT_W + FRAC_W;

   if (NUM_METERS < 1 || NUM_METERS > (1 << MNUM_W) || LEN_W > INT_W) begin : g_bad_cfg
      $fatal(1, "dual_bucket_meter: unsupported parameter set");
   end

   logic                  cmd_wr, rsel, fast_tick, slow_tick;
   param_t                ptype;
   logic [MNUM_W-1:0]     mnum;
   logic [NUM_METERS-1:0] mhit, take_w;
   logic [2:0]            ctrl_q [NUM_METERS];
   logic [FX_W-1:0]       rate_w [NUM_METERS][2];
   logic [4:0]            shift_w [NUM_METERS][2];
   logic [INT_W-1:0]      lvl_int_w [NUM_METERS][2];
   logic [FRAC_W-1:0]     lvl_frac_w [NUM_METERS][2];
   logic [2:0]            sel_ctrl;
   logic [INT_W-1:0]      sel_c, sel_p, cost;
   logic                  pass, sel_en;
   logic [31:0]           rd_lo, rd_hi;
   logic                  unused_cmd_bits;

   assign cmd_wr = cmd_word[31];
   assign ptype  = param_t'(cmd_word[29:28]);
   assign mnum   = {cmd_word[27:26], cmd_word[23:17]};
   assign rsel   = cmd_word[16];
   assign unused_cmd_bits = ^{cmd_word[30], cmd_word[25:24], cmd_word[15:0]};

   dbm_tick_gen u_tick (
      .clk(clk), .rst_n(rst_n), .fast_period(tick_fast), .slow_ratio(tick_ratio),
      .fast_tick(fast_tick), .slow_tick(slow_tick)
   );

   always_comb begin
      sel_ctrl = '0;
      sel_c    = '0;
      sel_p    = '0;
      for (int m = 0; m < NUM_METERS; m++) begin
         mhit[m] = (mnum == MNUM_W'(m));
         if (pkt_meter == MID_W'(m)) begin
            sel_ctrl = ctrl_q[m];
            sel_c    = lvl_int_w[m][0];
            sel_p    = lvl_int_w[m][1];
         end
      end
      sel_en = sel_ctrl[2];
      cost   = sel_ctrl[1] ? INT_W'(1) : INT_W'(pkt_len);
      pass   = (sel_c >= cost) && (sel_p >= cost);
   end

   for (genvar m = 0; m < NUM_METERS; m++) begin : g_meter
      logic tick_m, wr_m;
      assign tick_m    = ctrl_q[m][0] ? slow_tick : fast_tick;
      assign wr_m      = cmd_valid && cmd_wr && mhit[m];
      assign take_w[m] = pkt_valid && (pkt_meter == MID_W'(m)) && sel_en && pass;

      for (genvar b = 0; b < 2; b++) begin : g_bkt
         logic sel_b;
         assign sel_b = (rsel == 1'(b));
         dbm_bucket #(
            .INT_W(INT_W), .FRAC_W(FRAC_W), .SHIFT_MIN(SHIFT_MIN), .SHIFT_MAX(SHIFT_MAX)
         ) u_bkt (
            .clk(clk), .rst_n(rst_n), .tick(tick_m),
            .wr_rate (wr_m && sel_b && ptype == PT_RATE),
            .wr_shift(wr_m && sel_b && ptype == PT_SHIFT),
            .wr_level(wr_m && sel_b && ptype == PT_LEVEL),
            .wdata(wdata_lo), .take(take_w[m]), .cost(cost),
            .rate_o(rate_w[m][b]), .shift_o(shift_w[m][b]),
            .lvl_int_o(lvl_int_w[m][b]), .lvl_frac_o(lvl_frac_w[m][b])
         );
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int m = 0; m < NUM_METERS; m++) ctrl_q[m] <= '0;
      end else begin
         for (int m = 0; m < NUM_METERS; m++)
            if (cmd_valid && cmd_wr && mhit[m] && ptype == PT_CTRL) ctrl_q[m] <= wdata_lo[2:0];
      end
   end

   always_comb begin
      rd_lo = '0;
      rd_hi = '0;
      for (int m = 0; m < NUM_METERS; m++) begin
         if (mhit[m]) begin
            case (ptype)
               PT_CTRL:  rd_lo = 32'(ctrl_q[m]);
               PT_RATE:  rd_lo = 32'(rate_w[m][rsel]);
               PT_SHIFT: rd_lo = 32'(shift_w[m][rsel]);
               PT_LEVEL: begin
                  rd_lo = 32'(lvl_int_w[m][rsel]);
                  rd_hi = 32'(lvl_frac_w[m][rsel]);
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_done    <= 1'b0;
         rdata_lo    <= '0;
         rdata_hi    <= '0;
         dec_valid   <= 1'b0;
         dec_conform <= 1'b0;
      end else begin
         if (cmd_valid) cmd_done <= 1'b1;
         if (cmd_valid && !cmd_wr) begin
            rdata_lo <= rd_lo;
            rdata_hi <= rd_hi;
         end
         dec_valid   <= pkt_valid;
         dec_conform <= pkt_valid && (!sel_en || pass);
      end
   end

   a_r1_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> cmd_done);
   a_r8_dec_follows_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> dec_valid);
   a_r8_no_spurious_dec: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |=> !dec_valid);
   a_r9_disabled_conforms: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !sel_en) |=> dec_conform);
   a_r8_take_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_w));
endmodule

// File: tb/dual_bucket_meter_tb.sv
module dual_bucket_meter_tb;
   localparam int NM    = 3;
   localparam int MID_W = 2;
   localparam int LEN_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [15:0]      tick_fast = '0;
   logic [13:0]      tick_ratio = '0;
   logic             cmd_valid = 1'b0;
   logic [31:0]      cmd_word = '0;
   logic [31:0]      wdata_lo = '0;
   logic             cmd_done;
   logic [31:0]      rdata_lo, rdata_hi;
   logic             pkt_valid = 1'b0;
   logic [MID_W-1:0] pkt_meter = '0;
   logic [LEN_W-1:0] pkt_len = '0;
   logic             dec_valid, dec_conform;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;
   bit    exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   dual_bucket_meter #(.NUM_METERS(NM), .LEN_W(LEN_W), .MID_W(MID_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_ratio(tick_ratio),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .wdata_lo(wdata_lo),
      .cmd_done(cmd_done), .rdata_lo(rdata_lo), .rdata_hi(rdata_hi),
      .pkt_valid(pkt_valid), .pkt_meter(pkt_meter), .pkt_len(pkt_len),
      .dec_valid(dec_valid), .dec_conform(dec_conform)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic do_cmd(input bit wr, input int pt, input int m, input bit rt,
                         input logic [31:0] d, output logic [31:0] lo, output logic [31:0] hi);
      @(negedge clk);
      cmd_word  = {wr, 1'b0, 2'(pt), 2'(m >> 7), 2'b00, 7'(m & 127), rt, 16'h0};
      wdata_lo  = d;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      lo = rdata_lo;
      hi = rdata_hi;
   endtask

   task automatic wr(input int pt, input int m, input bit rt, input logic [31:0] d);
      logic [31:0] lo, hi;
      do_cmd(1'b1, pt, m, rt, d, lo, hi);
   endtask

   task automatic rd(input string tag, input int pt, input int m, input bit rt,
                     input logic [31:0] exp_lo, input logic [31:0] exp_hi);
      logic [31:0] lo, hi;
      do_cmd(1'b0, pt, m, rt, 32'h0, lo, hi);
      check(tag, lo, exp_lo);
      if (pt == 3 || exp_hi != 0) check(tag, hi, exp_hi);
   endtask

   task automatic run_ticks(input int ratio, input int n);
      @(negedge clk);
      tick_fast  = 16'd1;
      tick_ratio = 14'(ratio);
      repeat (n) @(negedge clk);
      tick_fast  = 16'd0;
      tick_ratio = 14'd0;
   endtask

   task automatic send_pkt(input int m, input int len, input bit exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      pkt_valid = 1'b1;
      pkt_meter = MID_W'(m);
      pkt_len   = LEN_W'(len);
      @(negedge clk);
      pkt_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R8: decision with none expected, got %0d expected none", dec_conform);
         end else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(dec_conform), 32'(e));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done at reset", 32'(cmd_done), 0);
      check("R8 no decision at reset", 32'(dec_valid), 0);
      rd("R3 ctrl reset", 0, 0, 0, 0, 0);
      check("R1 done after command", 32'(cmd_done), 1);
      rd("R5 shift reset", 2, 0, 0, 12, 0);
      rd("R4 rate reset", 1, 0, 1, 0, 0);

      // R5 clamping of the shift (meter 1 peak)
      wr(2, 1, 1, 3);            rd("R5 shift low clamp", 2, 1, 1, 12, 0);
      wr(2, 1, 1, 20);           rd("R5 shift high clamp", 2, 1, 1, 17, 0);
      wr(2, 1, 1, 32'hFFFF_FFFF); rd("R5 shift huge clamp", 2, 1, 1, 17, 0);
      wr(2, 1, 1, 14);           rd("R5 shift in range", 2, 1, 1, 14, 0);

      // R2 out-of-range meters
      wr(1, 128, 0, 7);  rd("R2 group meter reads 0", 1, 128, 0, 0, 0);
      rd("R2 meter 0 untouched", 1, 0, 0, 0, 0);
      wr(1, 3, 0, 9);    rd("R2 meter 3 reads 0", 1, 3, 0, 0, 0);

      // R11 separate buckets; rate 2.25 commit, 1.0 peak
      wr(1, 0, 0, 144);  wr(1, 0, 1, 64);
      rd("R11 commit rate", 1, 0, 0, 144, 0);
      rd("R11 peak rate", 1, 0, 1, 64, 0);

      // R4 fraction carry over 3 ticks
      run_ticks(0, 3);
      rd("R4 commit level 6.75", 3, 0, 0, 6, 48);
      rd("R11 peak level 3.0", 3, 0, 1, 3, 0);

      // R6 saturation at 2^12
      wr(1, 2, 0, 3000 << 6);
      run_ticks(0, 2);
      rd("R6 level capped", 3, 2, 0, 4096, 0);

      // R10 level writes
      wr(3, 2, 0, 5000); rd("R10 level write clamped", 3, 2, 0, 4096, 0);
      wr(3, 2, 0, 100);  rd("R10 level write", 3, 2, 0, 100, 0);

      // R7 slow tick on meter 1, fast on meter 0
      wr(0, 1, 0, 1);  wr(1, 1, 0, 64);  wr(3, 1, 0, 0);  wr(3, 0, 0, 0);
      run_ticks(4, 8);
      rd("R7 slow meter 2 ticks", 3, 1, 0, 2, 0);
      rd("R7 fast meter 8 ticks", 3, 0, 0, 18, 0);
      rd("R3 ctrl readback", 0, 1, 0, 1, 0);

      // R8 byte mode decisions
      wr(0, 0, 0, 4);  wr(3, 0, 0, 1000);  wr(3, 0, 1, 500);
      send_pkt(0, 400, 1, "R8 conform 400");
      rd("R8 commit drawn", 3, 0, 0, 600, 0);
      rd("R8 peak drawn", 3, 0, 1, 100, 0);
      send_pkt(0, 200, 0, "R8 exceed 200");
      rd("R8 exceed keeps peak", 3, 0, 1, 100, 0);
      rd("R8 exceed keeps commit", 3, 0, 0, 600, 0);
      send_pkt(0, 100, 1, "R8 conform at equality");
      rd("R8 peak emptied", 3, 0, 1, 0, 0);
      rd("R8 commit after equality", 3, 0, 0, 500, 0);

      // R8 packet mode
      wr(0, 0, 0, 6);
      send_pkt(0, 9, 0, "R8 packet mode empty exceed");
      wr(3, 0, 1, 2);
      send_pkt(0, 9999, 1, "R8 packet mode cost 1");
      send_pkt(0, 5, 1, "R8 back-to-back first");
      send_pkt(0, 5, 0, "R8 back-to-back second");
      rd("R8 packet mode peak", 3, 0, 1, 0, 0);
      rd("R8 packet mode commit", 3, 0, 0, 498, 0);

      // R9 disabled meter
      wr(0, 2, 0, 0);  wr(3, 2, 0, 100);  wr(3, 2, 1, 0);
      send_pkt(2, 50, 1, "R9 disabled conforms");
      rd("R9 level untouched", 3, 2, 0, 100, 0);

      repeat (4) @(negedge clk);
      check("R8 all decisions seen", 32'(exp_q.size()), 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule